// File: doc/BRIEF.md
# Dithered Channel Brightness Scaler

The block scales colour components by a brightness factor that is set separately for each of three channels. Every input byte carries a channel index. Before the scaling, the channel's current temporal dither offset is added to the byte and the sum is clamped to full scale. The result is then multiplied by the channel's 8-bit scale factor in eight pipelined shift-and-add steps. The output is the upper byte of the product and appears a fixed number of cycles after the input. The pipeline accepts a new byte on every cycle.

Each channel has its own dither offset. A frame-start strobe loads all the offsets from configuration inputs. After each pixel, a pixel-done strobe replaces each offset with the channel's mask value minus the current offset. Over successive pixels this alternates the rounding bias, so low brightness levels average out over time instead of truncating. A build parameter can remove the dither path. The latency stays the same when it does.

Top module: `chan_scaler`

## Requirements
- R1: An input byte of 0x00 gives an output byte of 0x00 whatever the channel's dither offset and scale.
- R2: For a nonzero input x, the value fed to the multiplier is x + d, where d is the channel's current offset. If that sum exceeds 0xFF, the value is 0xFF.
- R3: The output byte is (v * s) >> 8, where v is the value from R2 and s is the channel's scale. Channel c's scale is taken from bits [8c+7:8c] of `cfg_scale`.
- R4: An accepted byte appears on `out_byte` with `out_valid` high exactly 9 clock edges after it is presented. `out_chan` echoes its channel index. Bytes presented on consecutive cycles come out on consecutive cycles.
- R5: On a `pixel_done` strobe, each channel's offset becomes (m - d) mod 256, where m is the channel's mask from bits [8c+7:8c] of `cfg_mask`. A byte presented in a later cycle uses the new offset.
- R6: On a `frame_start` strobe, each channel's offset is loaded from bits [8c+7:8c] of `cfg_dither`. When both strobes arrive in the same cycle, `frame_start` wins.
- R7: Each channel's scale and offset affect only the bytes tagged with that channel.
- R8: A scale of 0xFF with an offset of 0 gives x - 1 for any nonzero x. A scale of 0x00 gives 0x00.
- R9: With the parameter `DITHER_EN` set to 0, no offset is added (v = x), and the latency is unchanged.
- R10: While reset is held, `out_valid` is 0 and every offset is 0.
- R11: A byte tagged with a channel index of 3 or more produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Loads every dither offset from `cfg_dither` |
| pixel_done | input | 1 | Steps every dither offset to mask minus offset |
| cfg_scale | input | 24 | Per-channel scale, channel 0 in the low byte |
| cfg_dither | input | 24 | Per-channel initial dither offset |
| cfg_mask | input | 24 | Per-channel dither mask |
| in_valid | input | 1 | Input byte present |
| in_chan | input | 2 | Channel index of the input byte |
| in_byte | input | 8 | Colour component |
| out_valid | output | 1 | Output byte present |
| out_chan | output | 2 | Channel index of the output byte |
| out_byte | output | 8 | Scaled component |

## Verification
The bench targets a set of corner cases, each chosen because a specific mistake would show up in it:
- A zero input on a channel with a nonzero offset. A design that skipped the bypass would put out a small nonzero value.
- A near-full input whose sum with the offset overflows. Without the clamp, the sum would wrap and the output would collapse to a tiny value.
- Full-scale and zero scale factors. An off-by-one in the shift-and-add chain would give x instead of x - 1.
- A frame-start strobe arriving together with a pixel-done strobe. If the priority were wrong, the next pixel would pick up the stepped offset and not the reloaded one.
- A second instance built without dither. It has to match the plain product with no extra latency.

// File: rtl/cs_pkg.sv
// Package for the channel scaler. It holds the data width, the width of
// the channel tag and the lane record that moves down the multiply pipeline.
// Assumes at most four channels, so a 2-bit tag is always enough.
package cs_pkg;
    localparam int DW      = 8;           // component and scale width
    localparam int CHW     = 2;           // channel tag width
    localparam int STEPS   = DW;          // one multiply step per scale bit
    localparam int LATENCY = STEPS + 1;   // prescale register plus steps

    typedef struct packed {
        logic           valid;
        logic [CHW-1:0] chan;
        logic [DW-1:0]  mcand;   // dithered, clamped multiplicand
        logic [DW-1:0]  scale;   // scale factor of this lane's channel
        logic [DW-1:0]  acc;     // running high byte of the product
    } lane_t;
endpackage

// File: rtl/cs_dither_bank.sv
// Holds one dither offset for each channel.
// frame_start loads the offsets from the configuration bus. pixel_done
// replaces each offset with mask minus offset. frame_start has priority.
// Assumes both strobes are single-cycle and synchronous to clk.
module cs_dither_bank #(
    parameter int NCH = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_start,
    input  logic                     pixel_done,
    input  logic [NCH*cs_pkg::DW-1:0] init_flat,
    input  logic [NCH*cs_pkg::DW-1:0] mask_flat,
    output logic [NCH*cs_pkg::DW-1:0] dither_flat
);
    import cs_pkg::*;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [DW-1:0] d_q;

        // Offset register for one channel: reset, reload or step.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d_q <= '0;
            end else if (frame_start) begin
                d_q <= init_flat[c*DW +: DW];
            end else if (pixel_done) begin
                d_q <= mask_flat[c*DW +: DW] - d_q;
            end
        end

        assign dither_flat[c*DW +: DW] = d_q;

        AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            frame_start |=> d_q == $past(init_flat[c*DW +: DW])); // R6
    end
endmodule

// File: rtl/cs_prescale.sv
// First pipeline stage. It selects the channel's offset and scale, adds the
// offset to a nonzero byte and clamps the sum at full scale. A zero byte
// skips the add. With DITHER_EN = 0 the add is left out and the stage
// still takes one cycle. Assumes the channel tag has been checked upstream.
module cs_prescale #(
    parameter int NCH       = 3,
    parameter bit DITHER_EN = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [cs_pkg::CHW-1:0]    in_chan,
    input  logic [cs_pkg::DW-1:0]     in_byte,
    input  logic [NCH*cs_pkg::DW-1:0] dither_flat,
    input  logic [NCH*cs_pkg::DW-1:0] scale_flat,
    output cs_pkg::lane_t             lane_q
);
    import cs_pkg::*;

    logic [DW-1:0] sel_d;
    logic [DW-1:0] sel_s;
    logic [DW-1:0] val;

    // Select this byte's channel offset and scale.
    always_comb begin
        sel_d = '0;
        sel_s = '0;
        for (int c = 0; c < NCH; c++) begin
            if (in_chan == CHW'(c)) begin
                sel_d = dither_flat[c*DW +: DW];
                sel_s = scale_flat[c*DW +: DW];
            end
        end
    end

    if (DITHER_EN) begin : g_dith
        logic [DW:0] sum;
        // Add the offset with saturation, bypassed for a zero byte.
        always_comb begin
            sum = {1'b0, in_byte} + {1'b0, sel_d};
            if (in_byte == '0)  val = '0;
            else if (sum[DW])   val = '1;
            else                val = sum[DW-1:0];
        end

        AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_byte != '0) |=> lane_q.mcand >= $past(in_byte)); // R2
    end else begin : g_plain
        // Pass the byte straight through when the dither path is removed.
        always_comb val = in_byte;
    end

    // Register the lane record that enters the multiplier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q.valid <= in_valid;
            lane_q.chan  <= in_chan;
            lane_q.mcand <= val;
            lane_q.scale <= sel_s;
            lane_q.acc   <= '0;
        end
    end

    AST_ZERO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_byte == '0) |=> lane_q.mcand == '0); // R1
endmodule

// File: rtl/cs_mul_step.sv
// One step of the shift-and-add multiplier. If scale bit BIT is set, the
// multiplicand is added to the accumulator. The 9-bit sum, carry included,
// is then shifted right by one. After the steps for bits 0..7 the
// accumulator holds (mcand*scale)>>8. Assumes the accumulator is 0 on
// entry to step 0.
module cs_mul_step #(
    parameter int BIT = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cs_pkg::lane_t lane_d,
    output cs_pkg::lane_t lane_q
);
    import cs_pkg::*;

    logic [DW:0] sum;

    // Conditional add of the multiplicand for this scale bit.
    always_comb begin
        sum = {1'b0, lane_d.acc};
        if (lane_d.scale[BIT]) sum = sum + {1'b0, lane_d.mcand};
    end

    // Register the lane with the accumulator rotated through the carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q     <= lane_d;
            lane_q.acc <= sum[DW:1];
        end
    end

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        lane_d.valid |=> lane_q.acc <= lane_q.mcand); // R3
endmodule

// File: rtl/chan_scaler.sv
// Top of the dithered channel brightness scaler. It builds the dither bank,
// the prescale stage and a chain of STEPS multiply stages, for a latency of
// LATENCY cycles. It accepts one byte per cycle. Assumes NCH <= 4 and that
// configuration changes take effect on the next accepted byte.
module chan_scaler #(
    parameter int NCH       = 3,
    parameter bit DITHER_EN = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_start,
    input  logic                      pixel_done,
    input  logic [NCH*cs_pkg::DW-1:0] cfg_scale,
    input  logic [NCH*cs_pkg::DW-1:0] cfg_dither,
    input  logic [NCH*cs_pkg::DW-1:0] cfg_mask,
    input  logic                      in_valid,
    input  logic [cs_pkg::CHW-1:0]    in_chan,
    input  logic [cs_pkg::DW-1:0]     in_byte,
    output logic                      out_valid,
    output logic [cs_pkg::CHW-1:0]    out_chan,
    output logic [cs_pkg::DW-1:0]     out_byte
);
    import cs_pkg::*;

    localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

    logic [NCH*DW-1:0] dither_flat;
    logic              chan_ok;
    lane_t             chain [STEPS+1];

    // Drop bytes whose channel tag is out of range.
    always_comb chan_ok = in_valid && (in_chan <= LAST_CH);

    cs_dither_bank #(.NCH(NCH)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .pixel_done  (pixel_done),
        .init_flat   (cfg_dither),
        .mask_flat   (cfg_mask),
        .dither_flat (dither_flat)
    );

    cs_prescale #(.NCH(NCH), .DITHER_EN(DITHER_EN)) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (chan_ok),
        .in_chan     (in_chan),
        .in_byte     (in_byte),
        .dither_flat (dither_flat),
        .scale_flat  (cfg_scale),
        .lane_q      (chain[0])
    );

    for (genvar k = 0; k < STEPS; k++) begin : g_step
        cs_mul_step #(.BIT(k)) u_step (
            .clk    (clk),
            .rst_n  (rst_n),
            .lane_d (chain[k]),
            .lane_q (chain[k+1])
        );
    end

    assign out_valid = chain[STEPS].valid;
    assign out_chan  = chain[STEPS].chan;
    assign out_byte  = chain[STEPS].acc;

    AST_BAD_CHAN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_chan > LAST_CH) |=> !chain[0].valid); // R11
    AST_VALID_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        chain[STEPS-1].valid |=> out_valid); // R4
endmodule

// File: tb/chan_scaler_bench.sv
`timescale 1ns/1ps
module chan_scaler_bench;
    localparam int LAT = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        pixel_done = 1'b0;
    logic [23:0] cfg_scale  = 24'h00_80_FF;
    logic [23:0] cfg_dither = 24'h05_10_00;
    logic [23:0] cfg_mask   = 24'hFF_30_20;
    logic        in_valid = 1'b0;
    logic [1:0]  in_chan = '0;
    logic [7:0]  in_byte = '0;
    logic        out_valid, nd_valid;
    logic [1:0]  out_chan, nd_chan;
    logic [7:0]  out_byte, nd_byte;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    chan_scaler u_chan_scaler (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pixel_done(pixel_done),
        .cfg_scale(cfg_scale), .cfg_dither(cfg_dither), .cfg_mask(cfg_mask),
        .in_valid(in_valid), .in_chan(in_chan), .in_byte(in_byte),
        .out_valid(out_valid), .out_chan(out_chan), .out_byte(out_byte));

    chan_scaler #(.DITHER_EN(1'b0)) u_chan_scaler_nd (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pixel_done(pixel_done),
        .cfg_scale(cfg_scale), .cfg_dither(cfg_dither), .cfg_mask(cfg_mask),
        .in_valid(in_valid), .in_chan(in_chan), .in_byte(in_byte),
        .out_valid(nd_valid), .out_chan(nd_chan), .out_byte(nd_byte));

    // {chan, byte, expected} with offsets 00/10/05 and scales FF/80/00
    localparam logic [17:0] VEC [8] = '{
        {2'd0, 8'h80, 8'h7F},   // R8 scale FF: x-1
        {2'd0, 8'h01, 8'h00},
        {2'd0, 8'h00, 8'h00},   // R1
        {2'd0, 8'hFF, 8'hFE},
        {2'd1, 8'h40, 8'h28},   // R2 R3 (0x50*0x80)>>8
        {2'd1, 8'hF8, 8'h7F},   // R2 clamp to FF
        {2'd1, 8'h00, 8'h00},   // R1 with nonzero offset
        {2'd2, 8'h77, 8'h00}    // R8 scale 0
    };

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, got, exp);
        end
    endtask

    // Present one byte, check out_valid is still low one cycle early, then
    // sample the result at exactly LAT edges.
    task automatic run(input logic [1:0] ch, input logic [7:0] x,
                       input logic [7:0] exp, input string req);
        in_valid = 1'b1; in_chan = ch; in_byte = x;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT-2) @(negedge clk);
        check("R4 early", int'(out_valid), 0);
        @(negedge clk);
        check("R4 valid", int'(out_valid), 1);
        check("R4 chan", int'(out_chan), int'(ch));
        check(req, int'(out_byte), int'(exp));
    endtask

    task automatic strobe(input logic fs, input logic pd);
        frame_start = fs; pixel_done = pd;
        @(negedge clk);
        frame_start = 1'b0; pixel_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: offsets are 0 after reset, so 0x40*0x80>>8 = 0x20
        run(2'd1, 8'h40, 8'h20, "R10 offset zero");

        strobe(1'b1, 1'b0);
        for (int i = 0; i < 8; i++) begin
            run(VEC[i][17:16], VEC[i][15:8], VEC[i][7:0], "R1/R2/R3/R8 table");
        end

        // R9: the undithered instance sees no offset
        run(2'd1, 8'h40, 8'h28, "R3 dithered");
        check("R9 no dither", int'(nd_byte), 8'h20);
        run(2'd1, 8'hF8, 8'h7F, "R2 clamp");
        check("R9 no dither high", int'(nd_byte), 8'h7C);
        check("R9 latency", int'(nd_valid), 1);

        // R11: channel 3 is dropped
        in_valid = 1'b1; in_chan = 2'd3; in_byte = 8'h55;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT-1) @(negedge clk);
        check("R11 bad chan", int'(out_valid), 0);

        // R5: offsets become 20/20/FA
        strobe(1'b0, 1'b1);
        run(2'd0, 8'h80, 8'h9F, "R5 ch0 step");
        run(2'd1, 8'h40, 8'h30, "R5 ch1 step");
        run(2'd2, 8'h10, 8'h00, "R7 ch2 scale 0");
        cfg_scale[23:16] = 8'h40;
        run(2'd2, 8'h10, 8'h3F, "R7 ch2 own scale");
        // R5: second step returns to 00/10/05
        strobe(1'b0, 1'b1);
        run(2'd1, 8'h40, 8'h28, "R5 ch1 second step");
        run(2'd2, 8'h10, 8'h05, "R5 ch2 second step");

        // R6: reload wins over step; ch0 offset 08, step would give 20
        cfg_dither[7:0] = 8'h08;
        strobe(1'b1, 1'b1);
        run(2'd0, 8'h80, 8'h87, "R6 frame priority");

        // R4: back-to-back bytes leave on consecutive cycles
        in_valid = 1'b1; in_chan = 2'd0; in_byte = 8'h80;
        @(negedge clk);
        in_chan = 2'd1; in_byte = 8'h40;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT-2) @(negedge clk);
        check("R4 first of pair", int'(out_byte), 8'h87);
        @(negedge clk);
        check("R4 second of pair", int'(out_byte), 8'h28);
        check("R4 second chan", int'(out_chan), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule